// File: doc/BRIEF.md
# YCbCr Output Formatter with Colour Kill and Blue-Back

This block sits at the end of a video decoder. It takes one decoded pixel per active cycle as separate 8-bit luma, blue-difference and red-difference samples, and puts them on the output pins in one of three packings. Two packings use separate buses: luma on its own bus, with the chroma bus carrying either 4:2:2 or 4:1:1 subsampled chroma. The third packing multiplexes luma and chroma onto one bus at twice the pixel rate. In multiplexed mode the upstream stage holds each pixel for two clocks. No timing reference codes are inserted into the multiplexed stream.

The formatter also applies two picture overrides. A colour-kill input sets both chroma components to the neutral midpoint and leaves luma as it is. When blue-back is enabled and the sync-lock input is low, the formatter replaces every pixel with a fixed blue. The line-valid qualifier goes through the same single register stage as the data. Format, kill and blue-back enable are static mode inputs. They change only while line-valid is low.

A small state machine tracks where each active cycle falls inside its chroma group. Its states are `SLOT0`, `SLOT1`, `SLOT2` and `SLOT3`. `SLOT0` is also the idle state. The transitions are:
- Any cycle with line-valid low returns the machine to `SLOT0`.
- In a separate 4:2:2 format, `SLOT0` goes to `SLOT1` and `SLOT1` goes back to `SLOT0`.
- In 4:1:1 and multiplexed formats, the machine steps `SLOT0` → `SLOT1` → `SLOT2` → `SLOT3` → `SLOT0`.

Top module: `ycc_out_fmt`

## Requirements
- R1: While reset is asserted, out_valid is 0, out_y is 16 and out_c is 128.
- R2: out_valid equals the in_valid of the previous clock, and out_y/out_c belong to that same input cycle.
- R3: With fmt=00 (separate 4:2:2), out_y is the pixel's luma. out_c carries Cb on the first pixel of each pair and, on the second, the Cr sampled with the first.
- R4: With fmt=01 (separate 4:1:1), out_y is luma. out_c carries the first pixel's Cb on group pixel 0, that pixel's Cr on group pixel 1, and 128 on group pixels 2 and 3.
- R5: With fmt=10 (multiplexed), the bytes on out_y over four clocks are Cb0, Y0, Cr0, Y1, each pixel held for two clocks, and out_c stays at 128.
- R6: Grouping always restarts at the first active cycle after in_valid was low, whatever the length of the previous line.
- R7: With kill=1 and blue-back inactive, every chroma value sent is 128 and luma is unchanged.
- R8: With blue_en=1 and in_lock=0, every pixel is sent as Y=41, Cb=240, Cr=110, even when kill=1. With in_lock=1, decoded video is sent.
- R9: With blue_en=0, in_lock has no effect on the output.
- R10: For a cycle with in_valid low, the following clock shows out_y=16 and out_c=128.
- R11: fmt=11 behaves exactly as separate 4:2:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Active-pixel qualifier for the input sample |
| in_y | input | 8 | Decoded luma |
| in_cb | input | 8 | Decoded blue-difference chroma |
| in_cr | input | 8 | Decoded red-difference chroma |
| in_lock | input | 1 | Sync detected |
| fmt | input | 2 | 00 sep 4:2:2, 01 sep 4:1:1, 10 multiplexed, 11 as 00 |
| kill | input | 1 | Force neutral chroma |
| blue_en | input | 1 | Enable blue field when unlocked |
| out_y | output | 8 | Luma bus, or the byte stream in multiplexed mode |
| out_c | output | 8 | Chroma bus |
| out_valid | output | 1 | Registered active-pixel qualifier |

## Verification
The bench runs lines of odd length back to back in every format, so the grouping has to restart at each line. A design that carried its position across lines would send Cr where Cb belongs, or would shift the multiplexed byte order by one. In 4:2:2 and 4:1:1 the bench checks that the second pixel's chroma is the Cr sampled with the first pixel. A design that sent the second pixel's own Cr would show a visibly different value. Kill and blue-back are applied together to check their priority, and lock is dropped with blue-back disabled to confirm that the picture is unaffected.

// File: rtl/ycc_fmt_pkg.sv
package ycc_fmt_pkg;
    typedef enum logic [1:0] {
        FMT_SEP422 = 2'b00,
        FMT_SEP411 = 2'b01,
        FMT_MUX    = 2'b10,
        FMT_ALT    = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        SLOT0 = 2'd0,
        SLOT1 = 2'd1,
        SLOT2 = 2'd2,
        SLOT3 = 2'd3
    } slot_e;
endpackage

// File: rtl/ycc_slot_fsm.sv
module ycc_slot_fsm
    import ycc_fmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  fmt_e  fmt,
    output slot_e slot
);
    slot_e slot_q;
    slot_e slot_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT0;
        else        slot_q <= slot_d;
    end

    always_comb begin
        slot_d = SLOT0;
        if (in_valid) begin
            unique case (slot_q)
                SLOT0: slot_d = SLOT1;
                SLOT1: slot_d = (fmt == FMT_SEP411 || fmt == FMT_MUX) ? SLOT2 : SLOT0;
                SLOT2: slot_d = SLOT3;
                SLOT3: slot_d = SLOT0;
            endcase
        end
    end

    assign slot = slot_q;

    // R6: a gap cycle always returns the group position to the start
    assert_gap_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> slot_q == SLOT0);

    // R3/R11: two-pixel groups never reach the upper slots
    assert_pair_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && slot_q == SLOT1 && (fmt == FMT_SEP422 || fmt == FMT_ALT)) |=> slot_q == SLOT0);
endmodule

// File: rtl/ycc_subst.sv
module ycc_subst #(
    parameter int unsigned DW      = 8,
    parameter int unsigned BLUE_Y  = 41,
    parameter int unsigned BLUE_CB = 240,
    parameter int unsigned BLUE_CR = 110
) (
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_cb,
    input  logic [DW-1:0] in_cr,
    input  logic          in_lock,
    input  logic          blue_en,
    input  logic          kill,
    output logic [DW-1:0] eff_y,
    output logic [DW-1:0] eff_cb,
    output logic [DW-1:0] eff_cr
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    logic blue_act;
    assign blue_act = blue_en && !in_lock;

    always_comb begin
        if (blue_act) begin
            eff_y  = DW'(BLUE_Y);
            eff_cb = DW'(BLUE_CB);
            eff_cr = DW'(BLUE_CR);
        end else if (kill) begin
            eff_y  = in_y;
            eff_cb = MID;
            eff_cr = MID;
        end else begin
            eff_y  = in_y;
            eff_cb = in_cb;
            eff_cr = in_cr;
        end
    end
endmodule

// File: rtl/ycc_pack.sv
module ycc_pack
    import ycc_fmt_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned BLANK_Y = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  fmt_e          fmt,
    input  slot_e         slot,
    input  logic [DW-1:0] eff_y,
    input  logic [DW-1:0] eff_cb,
    input  logic [DW-1:0] eff_cr,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_c,
    output logic          out_valid
);
    localparam logic [DW-1:0] MID   = DW'(1) << (DW - 1);
    localparam logic [DW-1:0] BLANK = DW'(BLANK_Y);

    logic [DW-1:0] hold_cr;
    logic [DW-1:0] pair_cr;
    logic [DW-1:0] y_d;
    logic [DW-1:0] c_d;

    // Cr of the group-leading pixel; bypass on the leading cycle itself
    assign pair_cr = (slot == SLOT0) ? eff_cr : hold_cr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        hold_cr <= MID;
        else if (in_valid && slot == SLOT0) hold_cr <= eff_cr;
    end

    always_comb begin
        y_d = BLANK;
        c_d = MID;
        if (in_valid) begin
            unique case (fmt)
                FMT_MUX: begin
                    c_d = MID;
                    unique case (slot)
                        SLOT0: y_d = eff_cb;
                        SLOT1: y_d = eff_y;
                        SLOT2: y_d = pair_cr;
                        SLOT3: y_d = eff_y;
                    endcase
                end
                FMT_SEP411: begin
                    y_d = eff_y;
                    unique case (slot)
                        SLOT0: c_d = eff_cb;
                        SLOT1: c_d = pair_cr;
                        SLOT2: c_d = MID;
                        SLOT3: c_d = MID;
                    endcase
                end
                FMT_SEP422, FMT_ALT: begin
                    y_d = eff_y;
                    c_d = (slot == SLOT0) ? eff_cb : pair_cr;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_y     <= BLANK;
            out_c     <= MID;
            out_valid <= 1'b0;
        end else begin
            out_y     <= y_d;
            out_c     <= c_d;
            out_valid <= in_valid;
        end
    end

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_blank_fill_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && out_y == BLANK && out_c == MID));

    assert_mux_chroma_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == FMT_MUX) |=> out_c == MID);

    assert_411_tail_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == FMT_SEP411 && slot == SLOT2) |=> out_c == MID);
endmodule

// File: rtl/ycc_out_fmt.sv
module ycc_out_fmt
    import ycc_fmt_pkg::*;
#(
    parameter int unsigned DW      = 8,
    parameter int unsigned BLANK_Y = 16,
    parameter int unsigned BLUE_Y  = 41,
    parameter int unsigned BLUE_CB = 240,
    parameter int unsigned BLUE_CR = 110
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_y,
    input  logic [DW-1:0] in_cb,
    input  logic [DW-1:0] in_cr,
    input  logic          in_lock,
    input  logic [1:0]    fmt,
    input  logic          kill,
    input  logic          blue_en,
    output logic [DW-1:0] out_y,
    output logic [DW-1:0] out_c,
    output logic          out_valid
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    fmt_e          fmt_q;
    slot_e         slot;
    logic [DW-1:0] eff_y;
    logic [DW-1:0] eff_cb;
    logic [DW-1:0] eff_cr;

    assign fmt_q = fmt_e'(fmt);

    ycc_slot_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .fmt      (fmt_q),
        .slot     (slot)
    );

    ycc_subst #(
        .DW      (DW),
        .BLUE_Y  (BLUE_Y),
        .BLUE_CB (BLUE_CB),
        .BLUE_CR (BLUE_CR)
    ) u_subst (
        .in_y    (in_y),
        .in_cb   (in_cb),
        .in_cr   (in_cr),
        .in_lock (in_lock),
        .blue_en (blue_en),
        .kill    (kill),
        .eff_y   (eff_y),
        .eff_cb  (eff_cb),
        .eff_cr  (eff_cr)
    );

    ycc_pack #(
        .DW      (DW),
        .BLANK_Y (BLANK_Y)
    ) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .fmt       (fmt_q),
        .slot      (slot),
        .eff_y     (eff_y),
        .eff_cb    (eff_cb),
        .eff_cr    (eff_cr),
        .out_y     (out_y),
        .out_c     (out_c),
        .out_valid (out_valid)
    );

    assert_blue_luma_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && blue_en && !in_lock && fmt != 2'b10) |=> out_y == DW'(BLUE_Y));

    assert_kill_chroma_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kill && !(blue_en && !in_lock) && (fmt == 2'b00 || fmt == 2'b11))
        |=> out_c == MID);

    assert_unlock_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !blue_en && !kill && fmt == 2'b00) |=> out_y == $past(in_y));
endmodule

// File: tb/ycc_out_fmt_bench.sv
module ycc_out_fmt_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_y = 8'd0;
    logic [7:0] in_cb = 8'd0;
    logic [7:0] in_cr = 8'd0;
    logic       in_lock = 1'b1;
    logic [1:0] fmt = 2'b00;
    logic       kill = 1'b0;
    logic       blue_en = 1'b0;
    logic [7:0] out_y;
    logic [7:0] out_c;
    logic       out_valid;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic  q_v[$];
    int    q_y[$];
    int    q_c[$];
    string q_tag[$];

    int m_slot = 0;
    int m_hcr = 128;

    always #2 clk = ~clk;

    ycc_out_fmt u_ycc_out_fmt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_y(in_y),
        .in_cb(in_cb), .in_cr(in_cr), .in_lock(in_lock), .fmt(fmt),
        .kill(kill), .blue_en(blue_en), .out_y(out_y), .out_c(out_c),
        .out_valid(out_valid)
    );

    task automatic drive(input bit v, input int y, input int cb, input int cr, input string tag);
        int ey, ecb, ecr, xy, xc, grp;
        @(negedge clk);
        in_valid = v; in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
        if (!v) begin
            xy = 16; xc = 128; m_slot = 0;
        end else begin
            if (blue_en && !in_lock) begin ey = 41; ecb = 240; ecr = 110; end
            else if (kill)           begin ey = y;  ecb = 128; ecr = 128; end
            else                     begin ey = y;  ecb = cb;  ecr = cr;  end
            if (m_slot == 0) m_hcr = ecr;
            grp = 2;
            if (fmt == 2'b10) begin
                grp = 4; xc = 128;
                xy = (m_slot == 0) ? ecb : (m_slot == 2) ? m_hcr : ey;
            end else if (fmt == 2'b01) begin
                grp = 4; xy = ey;
                xc = (m_slot == 0) ? ecb : (m_slot == 1) ? m_hcr : 128;
            end else begin
                xy = ey;
                xc = (m_slot == 0) ? ecb : m_hcr;
            end
            m_slot = (m_slot + 1) % grp;
        end
        q_v.push_back(v); q_y.push_back(xy); q_c.push_back(xc); q_tag.push_back(tag);
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, "R10");
    endtask

    task automatic line(input int n, input int base, input string tag);
        for (int i = 0; i < n; i++) drive(1, base + i, 60 + 3 * i, 190 - 5 * i, tag);
    endtask

    task automatic mux_line(input int n, input int base, input string tag);
        for (int i = 0; i < n; i++) begin
            drive(1, base + i, 70 + 7 * i, 180 - 9 * i, tag);
            drive(1, base + i, 70 + 7 * i, 180 - 9 * i, tag);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (q_v.size() > 0) begin
            logic ev; int ey2, ec2; string t;
            ev = q_v.pop_front(); ey2 = q_y.pop_front(); ec2 = q_c.pop_front(); t = q_tag.pop_front();
            n_run++;
            if (out_valid !== ev || out_y !== 8'(ey2) || out_c !== 8'(ec2)) begin
                n_fail++;
                $display("FAIL %s: got v=%0d y=%0d c=%0d exp v=%0d y=%0d c=%0d",
                         t, out_valid, out_y, out_c, ev, ey2, ec2);
            end
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hang exp completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (out_valid !== 1'b0 || out_y !== 8'd16 || out_c !== 8'd128) begin
            n_fail++;
            $display("FAIL R1: got v=%0d y=%0d c=%0d exp v=0 y=16 c=128", out_valid, out_y, out_c);
        end
        @(negedge clk); rst_n = 1'b1;
        gap(2);
        // R3 separate 4:2:2
        fmt = 2'b00; line(6, 20, "R3"); gap(2);
        // R6 odd-length lines back to back
        line(3, 40, "R6"); gap(1); line(4, 50, "R6"); gap(1);
        // R4 separate 4:1:1
        fmt = 2'b01; line(8, 80, "R4"); gap(1);
        line(5, 90, "R6"); gap(1); line(4, 95, "R6"); gap(2);
        // R5 multiplexed
        fmt = 2'b10; mux_line(4, 110, "R5"); gap(1);
        mux_line(3, 120, "R6"); gap(1); mux_line(2, 130, "R6"); gap(2);
        // R2 short bursts
        fmt = 2'b00; drive(1, 5, 6, 7, "R2"); gap(1); drive(1, 8, 9, 10, "R2");
        drive(1, 11, 12, 13, "R2"); gap(2);
        // R7 kill
        kill = 1'b1; line(4, 140, "R7"); gap(1);
        fmt = 2'b10; mux_line(2, 150, "R7"); gap(1);
        fmt = 2'b01; line(4, 155, "R7"); gap(2);
        // R8 blue-back overrides kill
        blue_en = 1'b1; in_lock = 1'b0; fmt = 2'b00; line(4, 160, "R8"); gap(1);
        fmt = 2'b10; mux_line(2, 165, "R8"); gap(1);
        kill = 1'b0; in_lock = 1'b1; fmt = 2'b00; line(4, 170, "R8"); gap(2);
        // R9 unlock without blue-back
        blue_en = 1'b0; in_lock = 1'b0; line(4, 180, "R9"); gap(1);
        fmt = 2'b01; line(4, 185, "R9"); gap(2);
        // R11 code 11
        in_lock = 1'b1; fmt = 2'b11; line(5, 200, "R11"); gap(3);
        repeat (3) @(posedge clk);
        #2;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule